// File: doc/BRIEF.md
# JTAG Test Access Port with Instruction Decode

This block is the device side of an IEEE 1149.1 test port. A sixteen-state controller runs on the test clock `tck`. The level on `tms` at each rising edge picks the next state. A five-bit instruction register chooses which data register sits between `tdi` and `tdo`. Two data registers are built in: a one-bit bypass stage and a 32-bit identification register, whose value is a parameter. A boundary scan chain outside the block attaches through `bsr_tdo`. It is steered by the capture, shift and update strobes, the chain-select flag and the decoded instruction.

The test logic returns to Test-Logic-Reset through `tms` alone. Holding it high for five rising edges is enough from any state. `rst_n` is the chip's power-on reset. It only places the controller in Test-Logic-Reset before the first clock. Serial data has no valid/ready handshake, so there is no back-pressure. One bit moves on every `tck` cycle spent in a shift state. The host controls the pace entirely through `tck` and `tms`.

`tdi` is sampled on the rising edge of `tck`. `tdo` and `tdo_oe` change on the falling edge. Registers shift least significant bit first.

Top module: `jtag_tap`

## Requirements
- R1: `tms` held high for five consecutive rising edges of `tck` brings the controller to Test-Logic-Reset from any state, and `rst_n` low forces that state at once.
- R2: While the controller is in Test-Logic-Reset, `instr` reads 2'b10 (identification). A data scan started straight after reset shifts out the identification register.
- R3: In a data scan with the identification instruction, Capture-DR loads the parameter value `ID_VALUE` (default 32'h16410041). Its bit 0 appears first on `tdo`.
- R4: Capture-IR loads 5'b00001 into the instruction shift stage, so the first five `tdo` bits of an instruction scan are 1,0,0,0,0.
- R5: Opcode decode is as follows: 5'b11111 gives bypass (`instr`=2'b11), 5'b00000 gives extest (2'b00), 5'b00010 gives sample/preload (2'b01), and 5'b00001 gives identification (2'b10). The last opcode bit is taken on the edge that enters Exit1-IR. `instr` changes only on the edge that leaves Update-IR, or in Test-Logic-Reset.
- R6: Any opcode outside the four above decodes as bypass (2'b11).
- R7: With bypass selected, the path from `tdi` to `tdo` is one register stage. The first shifted-out bit is the captured 0, and each later bit is the `tdi` bit shifted one cycle earlier.
- R8: `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR. It is updated on the falling edge of `tck`.
- R9: `capture_dr`, `shift_dr` and `update_dr` are high exactly while the controller is in Capture-DR, Shift-DR and Update-DR. `sel_bsr` is high for extest and sample/preload. In those modes, `tdo` in Shift-DR carries the value `bsr_tdo` held at the preceding falling edge.
- R10: A data scan that passes through Exit1-DR, Pause-DR and Exit2-DR and back to Shift-DR loses no bits and repeats none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` pad driver |
| bsr_tdo | input | 1 | Serial output of the external boundary chain |
| capture_dr | output | 1 | Controller is in Capture-DR |
| shift_dr | output | 1 | Controller is in Shift-DR |
| update_dr | output | 1 | Controller is in Update-DR |
| sel_bsr | output | 1 | Boundary chain is the selected data register |
| instr | output | 2 | Decoded instruction: 00 extest, 01 sample/preload, 10 identification, 11 bypass |

## Verification
The assertions assume three things about the inputs. `rst_n` is pulsed once before the first `tck` edge. `tms` and `tdi` are stable across every rising edge of `tck`. `bsr_tdo` only moves away from the falling edge. The stimulus changes all inputs shortly after each falling edge, so every input is settled half a period before the rising edge that samples it. `tdo` is read in the same window, after the falling edge has updated it.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    ST_EX2DR  = 4'h0,
    ST_EX1DR  = 4'h1,
    ST_SHDR   = 4'h2,
    ST_PAUSDR = 4'h3,
    ST_SELIR  = 4'h4,
    ST_UPDR   = 4'h5,
    ST_CAPDR  = 4'h6,
    ST_SELDR  = 4'h7,
    ST_EX2IR  = 4'h8,
    ST_EX1IR  = 4'h9,
    ST_SHIR   = 4'hA,
    ST_PAUSIR = 4'hB,
    ST_IDLE   = 4'hC,
    ST_UPIR   = 4'hD,
    ST_CAPIR  = 4'hE,
    ST_RESET  = 4'hF
  } tap_state_e;

  typedef enum logic [1:0] {
    INS_EXTEST = 2'b00,
    INS_SAMPLE = 2'b01,
    INS_IDCODE = 2'b10,
    INS_BYPASS = 2'b11
  } tap_instr_e;

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    unique case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SELDR  : ST_IDLE;
      ST_SELDR:  nxt = tms ? ST_SELIR  : ST_CAPDR;
      ST_CAPDR:  nxt = tms ? ST_EX1DR  : ST_SHDR;
      ST_SHDR:   nxt = tms ? ST_EX1DR  : ST_SHDR;
      ST_EX1DR:  nxt = tms ? ST_UPDR   : ST_PAUSDR;
      ST_PAUSDR: nxt = tms ? ST_EX2DR  : ST_PAUSDR;
      ST_EX2DR:  nxt = tms ? ST_UPDR   : ST_SHDR;
      ST_UPDR:   nxt = tms ? ST_SELDR  : ST_IDLE;
      ST_SELIR:  nxt = tms ? ST_RESET  : ST_CAPIR;
      ST_CAPIR:  nxt = tms ? ST_EX1IR  : ST_SHIR;
      ST_SHIR:   nxt = tms ? ST_EX1IR  : ST_SHIR;
      ST_EX1IR:  nxt = tms ? ST_UPIR   : ST_PAUSIR;
      ST_PAUSIR: nxt = tms ? ST_EX2IR  : ST_PAUSIR;
      ST_EX2IR:  nxt = tms ? ST_UPIR   : ST_SHIR;
      ST_UPIR:   nxt = tms ? ST_SELDR  : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= nxt;
  end

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
#(
  parameter int             IR_W      = 5,
  parameter logic [IR_W-1:0] OP_BYPASS = 5'b11111,
  parameter logic [IR_W-1:0] OP_EXTEST = 5'b00000,
  parameter logic [IR_W-1:0] OP_SAMPLE = 5'b00010,
  parameter logic [IR_W-1:0] OP_IDCODE = 5'b00001
) (
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_so,
  output tap_instr_e instr
);

  localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-1){1'b0}}, 1'b1};

  logic [IR_W-1:0] sr_q;
  tap_instr_e      instr_q;

  function automatic tap_instr_e decode(input logic [IR_W-1:0] op);
    if      (op == OP_EXTEST) return INS_EXTEST;
    else if (op == OP_SAMPLE) return INS_SAMPLE;
    else if (op == OP_IDCODE) return INS_IDCODE;
    else                      return INS_BYPASS; // bypass code and all unknown codes
  endfunction

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= CAP_PAT;
    end else if (state == ST_CAPIR) begin
      sr_q <= CAP_PAT;
    end else if (state == ST_SHIR) begin
      sr_q <= {tdi, sr_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                  instr_q <= INS_IDCODE;
    else if (state == ST_RESET)  instr_q <= INS_IDCODE;
    else if (state == ST_UPIR)   instr_q <= decode(sr_q);
  end

  assign ir_so = sr_q[0];
  assign instr = (state == ST_RESET) ? INS_IDCODE : instr_q;

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h16410041
) (
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  tap_instr_e instr,
  input  logic       tdi,
  input  logic       bsr_so,
  output logic       sel_bsr,
  output logic       dr_so
);

  logic            byp_q;
  logic [ID_W-1:0] id_q;
  logic            sel_id, sel_byp, cap, shf;

  assign sel_bsr = (instr == INS_EXTEST) || (instr == INS_SAMPLE);
  assign sel_id  = (instr == INS_IDCODE);
  assign sel_byp = (instr == INS_BYPASS);
  assign cap     = (state == ST_CAPDR);
  assign shf     = (state == ST_SHDR);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                byp_q <= 1'b0;
    else if (sel_byp && cap)   byp_q <= 1'b0;
    else if (sel_byp && shf)   byp_q <= tdi;
  end

  for (genvar g = 0; g < ID_W; g++) begin : g_id
    logic din;
    if (g == ID_W - 1) begin : g_top
      assign din = tdi;
    end else begin : g_mid
      assign din = id_q[g+1];
    end
    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)              id_q[g] <= ID_VALUE[g];
      else if (sel_id && cap)  id_q[g] <= ID_VALUE[g];
      else if (sel_id && shf)  id_q[g] <= din;
    end
  end

  always_comb begin
    if (sel_bsr)     dr_so = bsr_so;
    else if (sel_id) dr_so = id_q[0];
    else             dr_so = byp_q;
  end

endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
  import jtag_tap_pkg::*;
#(
  parameter int              IR_W     = 5,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h16410041
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdo,
  output logic       tdo_oe,
  input  logic       bsr_tdo,
  output logic       capture_dr,
  output logic       shift_dr,
  output logic       update_dr,
  output logic       sel_bsr,
  output logic [1:0] instr
);

  tap_state_e state;
  tap_instr_e instr_e;
  logic       ir_so, dr_so, shift_any;

  jtag_tap_fsm u_fsm (
    .tck(tck), .rst_n(rst_n), .tms(tms), .state(state)
  );

  jtag_tap_ir #(.IR_W(IR_W)) u_ir (
    .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
    .ir_so(ir_so), .instr(instr_e)
  );

  jtag_tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .rst_n(rst_n), .state(state), .instr(instr_e), .tdi(tdi),
    .bsr_so(bsr_tdo), .sel_bsr(sel_bsr), .dr_so(dr_so)
  );

  assign shift_any = (state == ST_SHIR) || (state == ST_SHDR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shift_any;
      if (shift_any) tdo <= (state == ST_SHIR) ? ir_so : dr_so;
    end
  end

  assign capture_dr = (state == ST_CAPDR);
  assign shift_dr   = (state == ST_SHDR);
  assign update_dr  = (state == ST_UPDR);
  assign instr      = instr_e;

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
  import jtag_tap_pkg::*;
(
  input logic       tck,
  input logic       rst_n,
  input logic       tms,
  input logic [3:0] state,
  input logic [1:0] instr,
  input logic       tdo_oe,
  input logic       shift_dr,
  input logic       update_dr
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                ones_cnt <= 3'd0;
    else if (!tms)             ones_cnt <= 3'd0;
    else if (ones_cnt != 3'd7) ones_cnt <= ones_cnt + 3'd1;
  end

  // R1
  tms_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_cnt >= 3'd5) |-> (state == ST_RESET));

  // R2
  reset_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
    ((state == ST_IDLE) && ($past(state) == ST_RESET)) |-> (instr == INS_IDCODE));

  // R5
  instr_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (($past(state) != ST_UPIR) && ($past(state) != ST_RESET) && (state != ST_RESET))
      |-> $stable(instr));

  // R8
  oe_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == ((state == ST_SHIR) || (state == ST_SHDR)));

  // R9
  shift_entry_chk: assert property (@(posedge tck) disable iff (!rst_n)
    shift_dr |-> (($past(state) == ST_CAPDR) || ($past(state) == ST_SHDR) ||
                  ($past(state) == ST_EX2DR)));

  // R9
  update_entry_chk: assert property (@(posedge tck) disable iff (!rst_n)
    update_dr |-> (($past(state) == ST_EX1DR) || ($past(state) == ST_EX2DR)));

endmodule

bind jtag_tap jtag_tap_chk u_chk (
  .tck(tck), .rst_n(rst_n), .tms(tms), .state(state), .instr(instr),
  .tdo_oe(tdo_oe), .shift_dr(shift_dr), .update_dr(update_dr)
);

// File: tb/tb_jtag_tap.sv
module tb_jtag_tap;

  localparam int TCK_PERIOD = 20;
  localparam logic [31:0] ID_EXP = 32'h16410041;

  logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_tdo = 1'b0;
  logic tdo, tdo_oe, capture_dr, shift_dr, update_dr, sel_bsr;
  logic [1:0] instr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(TCK_PERIOD/2) tck = ~tck;

  jtag_tap dut (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsr_tdo(bsr_tdo), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .sel_bsr(sel_bsr), .instr(instr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic d);
    tms = t; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic scan_ir(input logic [4:0] din, output logic [4:0] dout);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) begin
      dout[i] = tdo;
      step(i == 4, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input int pause_at,
                         output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0);
    check("R9 capture_dr", capture_dr, 1);
    step(0, 0);
    check("R8 oe in shift", tdo_oe, 1);
    check("R9 shift_dr", shift_dr, 1);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      if (pause_at == i + 1 && i != n - 1) begin
        step(1, din[i]); step(0, 0);
        check("R10 oe low in pause", tdo_oe, 0);
        step(1, 0); step(0, 0);
      end else begin
        step(i == n - 1, din[i]);
      end
    end
    step(1, 0);
    check("R9 update_dr", update_dr, 1);
    step(0, 0);
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check("R1 reset state oe", tdo_oe, 0);
    check("R2 instr in reset", instr, 2'b10);
    step(0, 0);
    check("R8 oe idle", tdo_oe, 0);
    scan_dr(32, 64'h0, 0, d);
    check("R2 R3 idcode after reset", d[31:0], ID_EXP);
  endtask

  task automatic t_ir_capture_bypass;
    logic [4:0] o;
    logic [63:0] d;
    scan_ir(5'b11111, o);
    check("R4 ir capture", o, 5'b00001);
    check("R5 bypass decode", instr, 2'b11);
    check("R9 sel_bsr off", sel_bsr, 0);
    scan_dr(8, 64'hF3, 0, d);
    check("R7 bypass delay", d[7:0], 8'hE6);
    check("R5 instr held", instr, 2'b11);
  endtask

  task automatic t_undefined;
    logic [4:0] o;
    logic [63:0] d;
    scan_ir(5'b10101, o);
    check("R6 undefined as bypass", instr, 2'b11);
    scan_dr(6, 64'h2D, 0, d);
    check("R6 R7 undefined path", d[5:0], 6'h1A);
  endtask

  task automatic t_idcode_pause;
    logic [4:0] o;
    logic [63:0] d;
    scan_ir(5'b00001, o);
    check("R5 idcode decode", instr, 2'b10);
    scan_dr(40, 64'hAB_0000_0000, 11, d);
    check("R10 id across pause", d[31:0], ID_EXP);
    check("R3 tdi tail", d[39:32], 8'h00);
  endtask

  task automatic t_sample;
    logic [4:0] o;
    logic [7:0] pat = 8'b1011_0010;
    scan_ir(5'b00010, o);
    check("R5 sample decode", instr, 2'b01);
    check("R9 sel_bsr sample", sel_bsr, 1);
    step(1, 0); step(0, 0);
    check("R9 capture strobe", capture_dr, 1);
    step(0, 0);
    for (int i = 0; i < 8; i++) begin
      bsr_tdo = pat[i];
      step(i == 7, 0);
      if (i < 7) check("R9 bsr relay", tdo, pat[i]);
    end
    check("R9 shift ends", shift_dr, 0);
    step(1, 0);
    check("R9 update strobe", update_dr, 1);
    step(0, 0);
  endtask

  task automatic t_extest_tms_reset;
    logic [4:0] o;
    logic [63:0] d;
    scan_ir(5'b00000, o);
    check("R5 extest decode", instr, 2'b00);
    check("R9 sel_bsr extest", sel_bsr, 1);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    check("R1 R2 tms reset instr", instr, 2'b10);
    check("R1 oe after tms reset", tdo_oe, 0);
    step(0, 0);
    scan_dr(32, 64'h0, 0, d);
    check("R1 idcode after tms reset", d[31:0], ID_EXP);
  endtask

  initial begin
    #(TCK_PERIOD * 2 + 3);
    @(negedge tck); #1;
    rst_n = 1'b1;
    t_reset();
    t_ir_capture_bypass();
    t_undefined();
    t_idcode_pause();
    t_sample();
    t_extest_tms_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge tck);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule